// File: doc/BRIEF.md
# Interrupt and Trap Entry Sequencer

This block sits beside an instruction sequencer and takes over at every instruction boundary. It samples the pending event sources, which are a divide fault, a software interrupt with its own vector, an overflow-check operation, a non-maskable request, a maskable external request with an outside-supplied vector, and a single-step trap. It picks one of them by fixed priority. It then saves the machine state on the stack, reads the handler address from the vector table at the bottom of memory, and hands the new CS, IP, SP and flags back to the core.

A return request runs the reverse sequence. It reads IP, CS and the flags back off the stack and reports them together with the adjusted SP. The single-step decision uses the trap enable that was in force while the finished instruction ran. An instruction that turns the trap enable off is therefore still followed by one trap.

The stack port is a plain word port. A read returns its data on the cycle after the read strobe. Every stack address is SS*16+SP, truncated to 20 bits.

Top module: `int_entry_seq`

## Requirements
- R1: After reset `busy`, `done` and `done_ret` are low, and no single-step trap is armed.
- R2: At a boundary the vector is chosen in this order: divide fault (vector 0), software interrupt (`swi_vec`), overflow check with O (flags bit 11) set (vector 4), non-maskable request (vector 2), maskable request with I (flags bit 9) set (`intr_vec`), single-step (vector 1).
- R3: The overflow check is ignored when O is clear, and the maskable request is ignored when I is clear. A boundary with nothing to take leaves `busy` and `done` low.
- R4: A single-step trap is taken at a boundary exactly when T (flags bit 8) was set at the previous boundary, and that previous boundary did not start an entry. After a return, T from the restored flags applies instead.
- R5: Entry writes the flags word to SS*16+(SP-2), CS to SS*16+(SP-4) and IP to SS*16+(SP-6), in that order, one write per cycle. It never reads and writes in the same cycle.
- R6: Entry reports new IP = word at byte address vector*4, new CS = word at vector*4+2, new SP = SP-6, and new flags = saved flags with I and T cleared.
- R7: `done` is a one-cycle pulse seen 7 cycles after the boundary cycle for an entry, and 5 cycles after the request cycle for a return. `busy` is high in between and low while `done` is high.
- R8: A return reads IP from SS*16+SP, CS from SP+2 and flags from SP+4. It reports them with new SP = SP+6 and raises `done_ret` with `done`.
- R9: `boundary` and `iret_req` are ignored while `busy` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| boundary | input | 1 | An instruction has just finished |
| iret_req | input | 1 | Start the return sequence |
| div_err | input | 1 | Divide fault from the finished instruction |
| swi_req | input | 1 | Software interrupt instruction finished |
| swi_vec | input | 8 | Vector of the software interrupt |
| into_op | input | 1 | Overflow-check operation finished |
| nmi_req | input | 1 | Non-maskable request pending |
| intr_req | input | 1 | Maskable external request pending |
| intr_vec | input | 8 | Vector supplied with the maskable request |
| cur_cs | input | 16 | Current code segment |
| cur_ip | input | 16 | Current instruction pointer |
| cur_sp | input | 16 | Current stack pointer |
| cur_ss | input | 16 | Current stack segment |
| cur_flags | input | 16 | Current flags word |
| mem_addr | output | 20 | Stack or vector table byte address |
| mem_wdata | output | 16 | Word to write |
| mem_we | output | 1 | Write strobe |
| mem_re | output | 1 | Read strobe, data expected next cycle |
| mem_rdata | input | 16 | Read data |
| busy | output | 1 | A sequence is running |
| done | output | 1 | Sequence finished, new values valid |
| done_ret | output | 1 | The finished sequence was a return |
| done_vec | output | 8 | Vector taken by the last entry |
| new_cs | output | 16 | Next code segment |
| new_ip | output | 16 | Next instruction pointer |
| new_sp | output | 16 | Next stack pointer |
| new_flags | output | 16 | Next flags word |

## Verification
A wrong stacked value or a corrupted stack pointer stays hidden until the stack memory is read back, or until a return restores it. The bench therefore checks memory contents after every entry and runs returns against those frames. A wrongly kept or lost single-step arm shows only at the next boundary, as a trap that appears or goes missing, so the bench tracks the arm in its own model across every boundary. Priority or mask errors show 7 cycles after the boundary in `done_vec` and `new_ip`.

// File: rtl/int_entry_seq.sv
module int_entry_seq #(
  parameter int TF_BIT = 8,
  parameter int IF_BIT = 9,
  parameter int OF_BIT = 11
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        boundary,
  input  logic        iret_req,
  input  logic        div_err,
  input  logic        swi_req,
  input  logic [7:0]  swi_vec,
  input  logic        into_op,
  input  logic        nmi_req,
  input  logic        intr_req,
  input  logic [7:0]  intr_vec,
  input  logic [15:0] cur_cs,
  input  logic [15:0] cur_ip,
  input  logic [15:0] cur_sp,
  input  logic [15:0] cur_ss,
  input  logic [15:0] cur_flags,
  output logic [19:0] mem_addr,
  output logic [15:0] mem_wdata,
  output logic        mem_we,
  output logic        mem_re,
  input  logic [15:0] mem_rdata,
  output logic        busy,
  output logic        done,
  output logic        done_ret,
  output logic [7:0]  done_vec,
  output logic [15:0] new_cs,
  output logic [15:0] new_ip,
  output logic [15:0] new_sp,
  output logic [15:0] new_flags
);
  localparam logic [7:0] VEC_DIV  = 8'd0;
  localparam logic [7:0] VEC_STEP = 8'd1;
  localparam logic [7:0] VEC_NMI  = 8'd2;
  localparam logic [7:0] VEC_OVF  = 8'd4;
  localparam logic [15:0] CLR_MASK = ~((16'd1 << TF_BIT) | (16'd1 << IF_BIT));

  typedef enum logic [3:0] {
    S_IDLE, S_PSH_F, S_PSH_C, S_PSH_I, S_VEC_I, S_VEC_C, S_ENT_END,
    S_POP_I, S_POP_C, S_POP_F, S_RET_END
  } st_t;

  st_t         st;
  logic [7:0]  vec_r;
  logic [15:0] cs_r, ip_r, sp_r, ss_r, fl_r;
  logic        armed;

  wire exc_hit  = div_err | swi_req | (into_op & cur_flags[OF_BIT]);
  wire mask_hit = intr_req & cur_flags[IF_BIT];
  wire take     = exc_hit | nmi_req | mask_hit | armed;
  wire idle     = (st == S_IDLE);

  logic [7:0] sel_vec;
  always_comb begin
    if (div_err)       sel_vec = VEC_DIV;
    else if (swi_req)  sel_vec = swi_vec;
    else if (exc_hit)  sel_vec = VEC_OVF;
    else if (nmi_req)  sel_vec = VEC_NMI;
    else if (mask_hit) sel_vec = intr_vec;
    else               sel_vec = VEC_STEP;
  end

  wire [15:0] sp_dec   = sp_r - 16'd2;
  wire [19:0] seg_base = {ss_r, 4'h0};
  wire        pushing  = (st == S_PSH_F) | (st == S_PSH_C) | (st == S_PSH_I);
  wire        popping  = (st == S_POP_I) | (st == S_POP_C) | (st == S_POP_F);

  assign mem_we = pushing;
  assign mem_re = popping | (st == S_VEC_I) | (st == S_VEC_C);
  assign busy   = !idle;

  always_comb begin
    if (pushing)               mem_addr = seg_base + {4'h0, sp_dec};
    else if (popping)          mem_addr = seg_base + {4'h0, sp_r};
    else if (st == S_VEC_C)    mem_addr = {10'd0, vec_r, 2'b10};
    else                       mem_addr = {10'd0, vec_r, 2'b00};
    case (st)
      S_PSH_F: mem_wdata = fl_r;
      S_PSH_C: mem_wdata = cs_r;
      default: mem_wdata = ip_r;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; vec_r <= '0; armed <= 1'b0;
      cs_r <= '0; ip_r <= '0; sp_r <= '0; ss_r <= '0; fl_r <= '0;
      done <= 1'b0; done_ret <= 1'b0; done_vec <= '0;
      new_cs <= '0; new_ip <= '0; new_sp <= '0; new_flags <= '0;
    end else begin
      done <= 1'b0;
      done_ret <= 1'b0;
      case (st)
        S_IDLE: begin
          if (iret_req) begin
            st <= S_POP_I; sp_r <= cur_sp; ss_r <= cur_ss;
          end else if (boundary) begin
            armed <= take ? 1'b0 : cur_flags[TF_BIT];
            if (take) begin
              st <= S_PSH_F; vec_r <= sel_vec;
              cs_r <= cur_cs; ip_r <= cur_ip; sp_r <= cur_sp;
              ss_r <= cur_ss; fl_r <= cur_flags;
            end
          end
        end
        S_PSH_F: begin st <= S_PSH_C; sp_r <= sp_dec; end
        S_PSH_C: begin st <= S_PSH_I; sp_r <= sp_dec; end
        S_PSH_I: begin st <= S_VEC_I; sp_r <= sp_dec; end
        S_VEC_I: st <= S_VEC_C;
        S_VEC_C: begin st <= S_ENT_END; ip_r <= mem_rdata; end
        S_ENT_END: begin
          st <= S_IDLE; done <= 1'b1; done_vec <= vec_r;
          new_ip <= ip_r; new_cs <= mem_rdata; new_sp <= sp_r;
          new_flags <= fl_r & CLR_MASK;
        end
        S_POP_I: begin st <= S_POP_C; sp_r <= sp_r + 16'd2; end
        S_POP_C: begin st <= S_POP_F; sp_r <= sp_r + 16'd2; ip_r <= mem_rdata; end
        S_POP_F: begin st <= S_RET_END; sp_r <= sp_r + 16'd2; cs_r <= mem_rdata; end
        S_RET_END: begin
          st <= S_IDLE; done <= 1'b1; done_ret <= 1'b1;
          new_ip <= ip_r; new_cs <= cs_r; new_sp <= sp_r;
          new_flags <= mem_rdata; armed <= mem_rdata[TF_BIT];
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/int_entry_seq_chk.sv
module int_entry_seq_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        busy,
  input logic        done,
  input logic        done_ret,
  input logic        mem_we,
  input logic        mem_re,
  input logic [15:0] new_flags
);
  AST_NO_RW_CLASH: assert property (@(posedge clk) disable iff (!rst_n) !(mem_we && mem_re)); // R5
  AST_WE_IN_SEQ: assert property (@(posedge clk) disable iff (!rst_n) mem_we |-> busy); // R5
  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n) done |-> !busy); // R7
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n) done |=> !done); // R7
  AST_RET_TAG: assert property (@(posedge clk) disable iff (!rst_n) done_ret |-> done); // R8
  AST_ENTRY_MASKS: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !done_ret) |-> (new_flags[9:8] == 2'b00)); // R6
endmodule

bind int_entry_seq int_entry_seq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .done(done), .done_ret(done_ret),
  .mem_we(mem_we), .mem_re(mem_re), .new_flags(new_flags)
);

// File: tb/int_entry_seq_test.sv
module int_entry_seq_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic boundary = 0, iret_req = 0, div_err = 0, swi_req = 0, into_op = 0, nmi_req = 0, intr_req = 0;
  logic [7:0] swi_vec = 0, intr_vec = 0;
  logic [15:0] cur_cs = 0, cur_ip = 0, cur_sp = 0, cur_ss = 0, cur_flags = 0;
  logic [19:0] mem_addr;
  logic [15:0] mem_wdata, mem_rdata = 0;
  logic mem_we, mem_re, busy, done, done_ret;
  logic [7:0] done_vec;
  logic [15:0] new_cs, new_ip, new_sp, new_flags;

  int_entry_seq uut (.*);

  logic [15:0] mem [int];
  function automatic logic [15:0] rd(int a);
    return mem.exists(a) ? mem[a] : 16'h0;
  endfunction
  always @(posedge clk) begin
    if (mem_re) mem_rdata <= rd(int'(mem_addr));
    if (mem_we) mem[int'(mem_addr)] = mem_wdata;
  end

  int tests = 0, fails = 0;
  logic bm_armed = 0;

  task automatic chk(input logic ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] tbl_ip(logic [7:0] v); return {v, 8'h10} ^ 16'h0a5c; endfunction
  function automatic logic [15:0] tbl_cs(logic [7:0] v); return 16'h3000 + {8'h0, v} * 16'd7; endfunction
  function automatic int phys(logic [15:0] ss, logic [15:0] sp);
    return int'(({ss, 4'h0} + {4'h0, sp}) & 20'hFFFFF);
  endfunction

  function automatic logic [8:0] pick(logic d, logic s, logic [7:0] sv, logic o, logic n,
                                      logic i, logic [7:0] iv, logic [15:0] fl, logic arm);
    if (d) return {1'b1, 8'd0};
    if (s) return {1'b1, sv};
    if (o && fl[11]) return {1'b1, 8'd4};
    if (n) return {1'b1, 8'd2};
    if (i && fl[9]) return {1'b1, iv};
    if (arm) return {1'b1, 8'd1};
    return 9'd0;
  endfunction

  task automatic clear_ev();
    boundary = 0; iret_req = 0; div_err = 0; swi_req = 0; into_op = 0; nmi_req = 0; intr_req = 0;
  endtask

  task automatic do_return(input logic [15:0] sp0, input logic [15:0] ss0, input logic [15:0] xip,
                           input logic [15:0] xcs, input logic [15:0] xfl);
    @(negedge clk);
    cur_sp = new_sp; cur_ss = ss0; iret_req = 1;
    @(negedge clk); iret_req = 0;
    chk(busy === 1'b1, "R7 busy during return", {31'd0, busy}, 1);
    repeat (3) @(negedge clk);
    chk(done === 1'b0, "R7 return not early", {31'd0, done}, 0);
    @(negedge clk);
    chk(done && done_ret, "R8 return done", {30'd0, done, done_ret}, 3);
    chk(new_ip == xip, "R8 popped ip", {16'd0, new_ip}, {16'd0, xip});
    chk(new_cs == xcs, "R8 popped cs", {16'd0, new_cs}, {16'd0, xcs});
    chk(new_flags == xfl, "R8 popped flags", {16'd0, new_flags}, {16'd0, xfl});
    chk(new_sp == sp0, "R8 sp restored", {16'd0, new_sp}, {16'd0, sp0});
    bm_armed = xfl[8];
  endtask

  task automatic step(input logic d, input logic s, input logic [7:0] sv, input logic o,
                      input logic n, input logic i, input logic [7:0] iv, input logic [15:0] fl,
                      input logic [15:0] ss, input logic [15:0] sp, input logic [15:0] cs,
                      input logic [15:0] ip, input logic with_ret, input string tag);
    logic [8:0] ev;
    ev = pick(d, s, sv, o, n, i, iv, fl, bm_armed);
    @(negedge clk);
    div_err = d; swi_req = s; swi_vec = sv; into_op = o; nmi_req = n; intr_req = i; intr_vec = iv;
    cur_flags = fl; cur_ss = ss; cur_sp = sp; cur_cs = cs; cur_ip = ip; boundary = 1;
    @(negedge clk);
    clear_ev();
    if (!ev[8]) begin
      chk(!busy && !done, {tag, " R3 nothing taken"}, {30'd0, busy, done}, 0);
      bm_armed = fl[8];
      return;
    end
    bm_armed = 0;
    chk(busy === 1'b1, {tag, " R7 busy"}, {31'd0, busy}, 1);
    boundary = 1; nmi_req = 1; iret_req = 1;
    @(negedge clk); clear_ev();
    repeat (4) @(negedge clk);
    chk(done === 1'b0 && busy, {tag, " R7 entry not early"}, {30'd0, done, busy}, 1);
    @(negedge clk);
    chk(done && !done_ret && !busy, {tag, " R7 entry done"}, {29'd0, done, done_ret, busy}, 4);
    chk(done_vec == ev[7:0], {tag, " R2 vector"}, {24'd0, done_vec}, {24'd0, ev[7:0]});
    chk(new_ip == tbl_ip(ev[7:0]) && new_cs == tbl_cs(ev[7:0]), {tag, " R6 handler"},
        {new_cs, new_ip}, {tbl_cs(ev[7:0]), tbl_ip(ev[7:0])});
    chk(new_sp == sp - 16'd6, {tag, " R6 sp"}, {16'd0, new_sp}, {16'd0, sp - 16'd6});
    chk(new_flags == (fl & 16'hFCFF), {tag, " R6 flags"}, {16'd0, new_flags}, {16'd0, fl & 16'hFCFF});
    chk(rd(phys(ss, sp - 16'd2)) == fl && rd(phys(ss, sp - 16'd4)) == cs && rd(phys(ss, sp - 16'd6)) == ip,
        {tag, " R5 stack frame"}, {rd(phys(ss, sp - 16'd4)), rd(phys(ss, sp - 16'd6))}, {cs, ip});
    @(negedge clk);
    chk(!busy && !done, {tag, " R9 busy-time requests dropped"}, {30'd0, busy, done}, 0);
    if (with_ret) do_return(sp, ss, ip, cs, fl);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++; tests++;
    $display("FAIL R7 watchdog actual=hung expected=finished");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    for (int v = 0; v < 256; v++) begin
      mem[v * 4] = tbl_ip(8'(v));
      mem[v * 4 + 2] = tbl_cs(8'(v));
    end
    repeat (3) @(negedge clk);
    chk(!busy && !done && !done_ret, "R1 reset outputs", {29'd0, busy, done, done_ret}, 0);
    rst_n = 1;
    @(negedge clk);
    // R1: no trap armed after reset even with T set now
    step(0,0,0,0,0,0,0,16'h0102,16'h2000,16'h0100,16'h1111,16'h2222,0,"R1 start");
    // R4: instruction ran with T=1 and cleared T -> still one trap
    step(0,0,0,0,0,0,0,16'h0002,16'h2000,16'h0100,16'h1111,16'h2224,0,"R4 last trap");
    step(0,0,0,0,0,0,0,16'h0002,16'h2000,16'h0100,16'h1111,16'h2226,0,"R4 no more");
    // R3 masks
    step(0,0,0,1,0,0,0,16'h0002,16'h2000,16'h0100,16'h1111,16'h2228,0,"R3 into O clear");
    step(0,0,0,0,0,1,8'h40,16'h0002,16'h2000,16'h0100,16'h1111,16'h222a,0,"R3 intr I clear");
    step(0,0,0,1,0,0,0,16'h0802,16'h2000,16'h0100,16'h1111,16'h222c,1,"R2 into O set");
    // R2 priorities
    step(1,1,8'h21,1,1,1,8'h40,16'h0A02,16'h2000,16'h0100,16'h1111,16'h2230,0,"R2 div wins");
    step(0,1,8'hFF,1,1,1,8'h40,16'h0A02,16'h2000,16'h0100,16'h1111,16'h2232,1,"R2 swi FF");
    step(0,0,0,0,1,1,8'h40,16'h0202,16'h2000,16'h0100,16'h1111,16'h2234,0,"R2 nmi over intr");
    step(0,0,0,0,0,1,8'h40,16'h0302,16'h2000,16'h0100,16'h1111,16'h2236,1,"R2 intr");
    // R4: return restores T=1, next boundary traps
    step(0,1,8'h30,0,0,0,0,16'h0102,16'h2000,16'h0100,16'h1111,16'h2238,1,"R4 ret rearms");
    step(0,0,0,0,0,0,0,16'h0002,16'h2000,16'h0100,16'h1111,16'h223a,0,"R4 after return");
    for (int k = 0; k < 300; k++) begin
      logic [15:0] f, sp;
      f = 16'($urandom) | 16'h0002;
      sp = 16'($urandom) | 16'h0010;
      sp[0] = 1'b0;
      step(($urandom % 12) == 0, ($urandom % 6) == 0, 8'($urandom), ($urandom % 5) == 0,
           ($urandom % 6) == 0, ($urandom % 3) == 0, 8'($urandom), f,
           16'h0100 + 16'($urandom % 16'hE000), sp, 16'($urandom), 16'($urandom),
           ($urandom % 2) == 0, "R2 random");
    end
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule